// File: doc/BRIEF.md
# Flash Operation Timing Sequencer

This block sits between a register bus and an embedded NOR flash array. Software programs three timing registers with cycle counts and an address register, then writes a command word to the control register. The block picks one operation from the command (mass erase, page erase, program, reference-cell erase or trim recall) and steps the flash array through three counted phases. Busy is visible in the status register while the operation runs.

Every operation has the same shape: a setup phase with no strobe, an active phase that asserts the operation's strobe, a hold phase that asserts the non-volatile hold strobe, and one closing cycle. The active phase length depends on the operation. The address seen by the array is page-aligned for page erase, passed unchanged for program, and zero for every other operation.

Top module: `flash_op_seq`

## Requirements
- R1: After reset, busy is 0, every flash strobe is 0, `mac_addr` is 0 and every register reads back as 0.
- R2: Registers sit at byte offsets control 0x00, timing-A 0x04, timing-B 0x08, timing-C 0x0C, address 0x20 and status 0x2C, and only their defined fields are stored.
  - Timing-A keeps read wait states in [5:0] and the hold count in [31:16].
  - Timing-B keeps a 24-bit erase count in [23:0].
  - Timing-C keeps the program count in [15:0], the recall count in [23:16] and the setup count in [27:24].
  - The address register keeps its low FLASH_AW bits.
  - Every other bit reads 0. Status ignores writes.
- R3: A control write while idle that has any operation bit set starts an operation, and busy (status bit 0) reads 1 from the next cycle.
  - The operation bits are mass erase 3, page erase 4, program 5, reference erase 6 and recall 7.
  - While the operation runs, control reads the running operation as a single bit at its position.
  - Control also returns the stored flags: sleep in bit 0, write-protect in bit 1 and auto-program in bit 8.
- R4: An operation runs S+1 setup cycles with no strobe, then A+1 cycles with its strobe, then H+1 cycles with `mac_nvh`, then one more busy cycle. Busy therefore lasts S+A+H+4 cycles.
  - S is the setup count and H is the hold count.
  - A is the erase count for the three erase operations, the program count for program, and the recall count for recall.
- R5: When several operation bits are written together, only one starts. The order of precedence is mass erase, page erase, program, reference erase, recall.
- R6: A write to the control register while busy is ignored. It changes neither the flags nor the running operation, and it starts nothing after the current operation ends.
- R7: During an operation, `mac_addr` is 0 for mass erase, reference erase and recall. For page erase it is the address register with its low log2(PAGE_BYTES) bits cleared. For program it is the address register unchanged.
- R8: At most one of `mac_erase`, `mac_prog`, `mac_recall`, `mac_nvh` is high at a time. `mac_erase_all` (mass erase) and `mac_erase_ref` (reference erase) are only high together with `mac_erase`.
- R9: A control write with no operation bit set updates the sleep, write-protect and auto-program flags and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| busy | output | 1 | Operation in progress |
| mac_erase | output | 1 | Erase strobe (active phase of any erase) |
| mac_erase_all | output | 1 | Qualifies erase as whole-array |
| mac_erase_ref | output | 1 | Qualifies erase as reference cell |
| mac_prog | output | 1 | Program strobe |
| mac_recall | output | 1 | Trim recall strobe |
| mac_nvh | output | 1 | Non-volatile hold strobe |
| mac_addr | output | FLASH_AW | Array address for the running operation |

## Verification
The bench builds the block with FLASH_AW = 16, keeps the 4096-byte page and uses the combinational read path. With these settings the page-alignment mask and the address width limit both show up in readable 16-bit values. Phase lengths come from registers rather than parameters, so small programmed counts (including zero for every phase) give operations only a few cycles long. One erase count of 300 exercises a long active phase, and the all-ones register writes cover the full width of every field.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD, PH_FIN
   } phase_t;

   typedef enum logic [2:0] {
      OP_NONE, OP_MASS, OP_PAGE, OP_PROG, OP_REF, OP_RECALL
   } op_t;

   // register byte offsets
   localparam int OFS_CTRL   = 'h00;
   localparam int OFS_TIMA   = 'h04;
   localparam int OFS_TIMB   = 'h08;
   localparam int OFS_TIMC   = 'h0C;
   localparam int OFS_ADDR   = 'h20;
   localparam int OFS_STATUS = 'h2C;

   // control word bit positions
   localparam int CB_SLEEP  = 0;
   localparam int CB_WPROT  = 1;
   localparam int CB_MASS   = 3;
   localparam int CB_PAGE   = 4;
   localparam int CB_PROG   = 5;
   localparam int CB_REF    = 6;
   localparam int CB_RECALL = 7;
   localparam int CB_AUTO   = 8;

   // widest phase count field
   localparam int CNT_W = 24;

   function automatic op_t pick_op(input logic [31:0] w);
      if (w[CB_MASS])        return OP_MASS;
      else if (w[CB_PAGE])   return OP_PAGE;
      else if (w[CB_PROG])   return OP_PROG;
      else if (w[CB_REF])    return OP_REF;
      else if (w[CB_RECALL]) return OP_RECALL;
      else                   return OP_NONE;
   endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
   parameter int WIDTH = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [WIDTH-1:0] ld_val,
   output logic             zero
);
   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (ld)          cnt_q <= ld_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
   import flash_seq_pkg::*;
#(
   parameter int CW = CNT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  op_t           go_op,
   input  logic [3:0]    t_setup,
   input  logic [23:0]   t_erase,
   input  logic [15:0]   t_prog,
   input  logic [7:0]    t_rcl,
   input  logic [15:0]   t_nvh,
   input  logic          cnt_zero,
   output logic          ld,
   output logic [CW-1:0] ld_val,
   output phase_t        phase,
   output op_t           op
);
   phase_t ph_n;
   op_t    op_n;
   logic [CW-1:0] active_len;

   always_comb begin
      case (op)
         OP_MASS, OP_PAGE, OP_REF: active_len = CW'(t_erase);
         OP_PROG:                  active_len = CW'(t_prog);
         OP_RECALL:                active_len = CW'(t_rcl);
         default:                  active_len = '0;
      endcase
   end

   always_comb begin
      ph_n   = phase;
      op_n   = op;
      ld     = 1'b0;
      ld_val = '0;
      case (phase)
         PH_IDLE: if (go) begin
            ph_n   = PH_SETUP;
            op_n   = go_op;
            ld     = 1'b1;
            ld_val = CW'(t_setup);
         end
         PH_SETUP: if (cnt_zero) begin
            ph_n   = PH_ACTIVE;
            ld     = 1'b1;
            ld_val = active_len;
         end
         PH_ACTIVE: if (cnt_zero) begin
            ph_n   = PH_HOLD;
            ld     = 1'b1;
            ld_val = CW'(t_nvh);
         end
         PH_HOLD: if (cnt_zero) ph_n = PH_FIN;
         PH_FIN: begin
            ph_n = PH_IDLE;
            op_n = OP_NONE;
         end
         default: begin
            ph_n = PH_IDLE;
            op_n = OP_NONE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         op    <= OP_NONE;
      end else begin
         phase <= ph_n;
         op    <= op_n;
      end
   end
endmodule

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
   import flash_seq_pkg::*;
#(
   parameter int REG_AW    = 6,
   parameter int FLASH_AW  = 20,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [REG_AW-1:0]   addr,
   input  logic [31:0]         wdata,
   input  logic                busy,
   input  op_t                 run_op,
   output logic [31:0]         rdata,
   output logic                go,
   output op_t                 go_op,
   output logic [3:0]          t_setup,
   output logic [23:0]         t_erase,
   output logic [15:0]         t_prog,
   output logic [7:0]          t_rcl,
   output logic [15:0]         t_nvh,
   output logic [FLASH_AW-1:0] addr_q
);
   logic       sleep_q, wprot_q, auto_q;
   logic [5:0] wait_q;
   logic       sel_ctrl, sel_tima, sel_timb, sel_timc, sel_addr, sel_stat;
   logic [4:0] op_bits;
   logic [31:0] rd_mux;
   logic        unused_wdata;

   assign unused_wdata = ^wdata;

   assign sel_ctrl = (addr == REG_AW'(OFS_CTRL));
   assign sel_tima = (addr == REG_AW'(OFS_TIMA));
   assign sel_timb = (addr == REG_AW'(OFS_TIMB));
   assign sel_timc = (addr == REG_AW'(OFS_TIMC));
   assign sel_addr = (addr == REG_AW'(OFS_ADDR));
   assign sel_stat = (addr == REG_AW'(OFS_STATUS));

   assign go_op = pick_op(wdata);
   assign go    = wr && sel_ctrl && !busy && (go_op != OP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q <= 1'b0;
         wprot_q <= 1'b0;
         auto_q  <= 1'b0;
         wait_q  <= '0;
         t_nvh   <= '0;
         t_erase <= '0;
         t_prog  <= '0;
         t_rcl   <= '0;
         t_setup <= '0;
         addr_q  <= '0;
      end else if (wr) begin
         if (sel_ctrl && !busy) begin
            sleep_q <= wdata[CB_SLEEP];
            wprot_q <= wdata[CB_WPROT];
            auto_q  <= wdata[CB_AUTO];
         end
         if (sel_tima) begin
            wait_q <= wdata[5:0];
            t_nvh  <= wdata[31:16];
         end
         if (sel_timb) t_erase <= wdata[23:0];
         if (sel_timc) begin
            t_prog  <= wdata[15:0];
            t_rcl   <= wdata[23:16];
            t_setup <= wdata[27:24];
         end
         if (sel_addr) addr_q <= wdata[FLASH_AW-1:0];
      end
   end

   // running operation shown one-hot at its command bit position
   always_comb begin
      op_bits = '0;
      case (run_op)
         OP_MASS:   op_bits[CB_MASS-3]   = 1'b1;
         OP_PAGE:   op_bits[CB_PAGE-3]   = 1'b1;
         OP_PROG:   op_bits[CB_PROG-3]   = 1'b1;
         OP_REF:    op_bits[CB_REF-3]    = 1'b1;
         OP_RECALL: op_bits[CB_RECALL-3] = 1'b1;
         default:   op_bits = '0;
      endcase
   end

   always_comb begin
      rd_mux = '0;
      if (sel_ctrl) rd_mux = {23'd0, auto_q, op_bits, 1'b0, wprot_q, sleep_q};
      if (sel_tima) rd_mux = {t_nvh, 10'd0, wait_q};
      if (sel_timb) rd_mux = {8'd0, t_erase};
      if (sel_timc) rd_mux = {4'd0, t_setup, t_rcl, t_prog};
      if (sel_addr) rd_mux = 32'(addr_q);
      if (sel_stat) rd_mux = {31'd0, busy};
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
   import flash_seq_pkg::*;
#(
   parameter int REG_AW     = 6,
   parameter int FLASH_AW   = 20,
   parameter int PAGE_BYTES = 4096,
   parameter bit RDATA_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                busy,
   output logic                mac_erase,
   output logic                mac_erase_all,
   output logic                mac_erase_ref,
   output logic                mac_prog,
   output logic                mac_recall,
   output logic                mac_nvh,
   output logic [FLASH_AW-1:0] mac_addr
);
   localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
   localparam logic [FLASH_AW-1:0] PAGE_MASK = ~FLASH_AW'((1 << PAGE_SHIFT) - 1);

   generate
      if (REG_AW < 6) begin : g_bad_regaw
         $error("REG_AW must cover offset 0x2C");
      end
      if ((1 << PAGE_SHIFT) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (FLASH_AW <= PAGE_SHIFT || FLASH_AW > 32) begin : g_bad_aw
         $error("FLASH_AW must exceed the page offset and fit 32 bits");
      end
   endgenerate

   logic                go;
   op_t                 go_op, run_op;
   phase_t              phase;
   logic [3:0]          t_setup;
   logic [23:0]         t_erase;
   logic [15:0]         t_prog, t_nvh;
   logic [7:0]          t_rcl;
   logic [FLASH_AW-1:0] addr_q;
   logic                ld, cnt_zero, active, is_erase;
   logic [CNT_W-1:0]    ld_val;

   flash_seq_regs #(
      .REG_AW(REG_AW), .FLASH_AW(FLASH_AW), .RDATA_REG(RDATA_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .busy(busy), .run_op(run_op), .rdata(reg_rdata), .go(go), .go_op(go_op),
      .t_setup(t_setup), .t_erase(t_erase), .t_prog(t_prog), .t_rcl(t_rcl),
      .t_nvh(t_nvh), .addr_q(addr_q)
   );

   flash_seq_fsm #(.CW(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .go(go), .go_op(go_op), .t_setup(t_setup),
      .t_erase(t_erase), .t_prog(t_prog), .t_rcl(t_rcl), .t_nvh(t_nvh),
      .cnt_zero(cnt_zero), .ld(ld), .ld_val(ld_val), .phase(phase), .op(run_op)
   );

   flash_seq_timer #(.WIDTH(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .zero(cnt_zero)
   );

   assign busy     = (phase != PH_IDLE);
   assign active   = (phase == PH_ACTIVE);
   assign is_erase = (run_op == OP_MASS) || (run_op == OP_PAGE) || (run_op == OP_REF);

   assign mac_erase     = active && is_erase;
   assign mac_erase_all = active && (run_op == OP_MASS);
   assign mac_erase_ref = active && (run_op == OP_REF);
   assign mac_prog      = active && (run_op == OP_PROG);
   assign mac_recall    = active && (run_op == OP_RECALL);
   assign mac_nvh       = (phase == PH_HOLD);

   always_comb begin
      case (run_op)
         OP_PAGE: mac_addr = addr_q & PAGE_MASK;
         OP_PROG: mac_addr = addr_q;
         default: mac_addr = '0;
      endcase
   end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
   parameter int REG_AW     = 6,
   parameter int FLASH_AW   = 20,
   parameter int PAGE_SHIFT = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic [REG_AW-1:0]   reg_addr,
   input logic [31:0]         reg_wdata,
   input logic                busy,
   input logic                mac_erase,
   input logic                mac_erase_all,
   input logic                mac_erase_ref,
   input logic                mac_prog,
   input logic                mac_recall,
   input logic                mac_nvh,
   input logic [FLASH_AW-1:0] mac_addr
);
   logic any_strobe;
   assign any_strobe = mac_erase | mac_prog | mac_recall | mac_nvh;

   a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mac_erase, mac_prog, mac_recall, mac_nvh}));

   a_r8_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
      (mac_erase_all | mac_erase_ref) |-> mac_erase);

   a_r4_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      any_strobe |-> busy);

   a_r4_hold_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mac_nvh) |-> $past(mac_erase | mac_prog | mac_recall));

   a_r4_busy_tail: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!$past(mac_nvh) && $past(mac_nvh, 2)));

   a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0 && reg_wdata[7:3] != '0 && !busy) |=> busy);

   a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0 && reg_wdata[7:3] == '0 && !busy) |=> !busy);

   a_r7_mass_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mac_erase_all |-> (mac_addr == '0));

   a_r7_page_align: assert property (@(posedge clk) disable iff (!rst_n)
      (mac_erase && !mac_erase_all && !mac_erase_ref) |-> (mac_addr[PAGE_SHIFT-1:0] == '0));
endmodule

bind flash_op_seq flash_seq_chk #(
   .REG_AW(REG_AW), .FLASH_AW(FLASH_AW), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .busy(busy), .mac_erase(mac_erase),
   .mac_erase_all(mac_erase_all), .mac_erase_ref(mac_erase_ref),
   .mac_prog(mac_prog), .mac_recall(mac_recall), .mac_nvh(mac_nvh),
   .mac_addr(mac_addr)
);

// File: tb/sim_flash_op_seq.sv
module sim_flash_op_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;

   localparam logic [5:0] A_CTRL = 6'h00, A_TIMA = 6'h04, A_TIMB = 6'h08,
                          A_TIMC = 6'h0C, A_ADDR = 6'h20, A_STAT = 6'h2C;

   // kind: 1 mass, 2 page, 3 program, 4 reference erase, 5 recall
   typedef struct packed {
      logic [8:0]  ctrl;
      logic [3:0]  s;
      logic [11:0] e;
      logic [7:0]  p;
      logic [7:0]  r;
      logic [7:0]  h;
      logic [15:0] a;
      logic [2:0]  k;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{9'h008, 4'd2,  12'd5,   8'd0, 8'd0, 8'd3,   16'h1234, 3'd1},
      '{9'h010, 4'd0,  12'd0,   8'd0, 8'd0, 8'd0,   16'h5ABC, 3'd2},
      '{9'h020, 4'd1,  12'd9,   8'd7, 8'd2, 8'd2,   16'h0123, 3'd3},
      '{9'h040, 4'd3,  12'd4,   8'd1, 8'd1, 8'd1,   16'hFFFF, 3'd4},
      '{9'h080, 4'd0,  12'd2,   8'd3, 8'd6, 8'd5,   16'h8001, 3'd5},
      '{9'h0F8, 4'd1,  12'd3,   8'd4, 8'd5, 8'd1,   16'h7777, 3'd1},
      '{9'h0F0, 4'd2,  12'd1,   8'd4, 8'd5, 8'd2,   16'hE0FF, 3'd2},
      '{9'h0E0, 4'd0,  12'd6,   8'd2, 8'd5, 8'd0,   16'h0F0F, 3'd3},
      '{9'h0C0, 4'd1,  12'd2,   8'd9, 8'd5, 8'd1,   16'h3000, 3'd4},
      '{9'h1A2, 4'd1,  12'd8,   8'd3, 8'd1, 8'd4,   16'hABCD, 3'd3},
      '{9'h181, 4'd4,  12'd8,   8'd3, 8'd7, 8'd0,   16'h1111, 3'd5},
      '{9'h00B, 4'd15, 12'd300, 8'd0, 8'd0, 8'd255, 16'h0000, 3'd1}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        busy, mac_erase, mac_erase_all, mac_erase_ref;
   logic        mac_prog, mac_recall, mac_nvh;
   logic [AW-1:0] mac_addr;

   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_op_seq #(.REG_AW(6), .FLASH_AW(AW), .PAGE_BYTES(4096), .RDATA_REG(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .mac_erase(mac_erase), .mac_erase_all(mac_erase_all),
      .mac_erase_ref(mac_erase_ref), .mac_prog(mac_prog),
      .mac_recall(mac_recall), .mac_nvh(mac_nvh), .mac_addr(mac_addr)
   );

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int exp_a, cyc, first, n_str, n_other, n_nvh, n_badaddr, n_badq;
      logic [31:0] c, st, ec;
      logic [AW-1:0] ea;
      logic s_exp;
      exp_a = (v.k == 3'd3) ? int'(v.p) : (v.k == 3'd5) ? int'(v.r) : int'(v.e);
      ea    = (v.k == 3'd2) ? (v.a & 16'hF000) : (v.k == 3'd3) ? v.a : '0;
      ec    = 32'(v.ctrl & 9'h103) | (32'd1 << (v.k + 3'd2));
      wr(A_TIMA, {8'h00, v.h, 16'h0000});
      wr(A_TIMB, 32'(v.e));
      wr(A_TIMC, {4'h0, v.s, v.r, 8'h00, v.p});
      wr(A_ADDR, 32'(v.a));
      wr(A_CTRL, 32'(v.ctrl));
      rd(A_CTRL, c);
      rd(A_STAT, st);
      chk(c == ec, $sformatf("R3/R5 vec%0d control readback", idx), c, ec);
      chk(st == 32'd1, $sformatf("R3 vec%0d status busy", idx), st, 1);
      cyc = 0; first = -1; n_str = 0; n_other = 0; n_nvh = 0; n_badaddr = 0; n_badq = 0;
      while (busy && cyc < 5000) begin
         case (v.k)
            3'd1, 3'd2, 3'd4: s_exp = mac_erase;
            3'd3:             s_exp = mac_prog;
            default:          s_exp = mac_recall;
         endcase
         if (s_exp) begin
            n_str++;
            if (first < 0) first = cyc;
            if (mac_addr != ea) n_badaddr++;
            if (mac_erase_all != (v.k == 3'd1) || mac_erase_ref != (v.k == 3'd4)) n_badq++;
         end
         n_other += int'(mac_erase) + int'(mac_prog) + int'(mac_recall) - int'(s_exp);
         if (mac_nvh) n_nvh++;
         cyc++;
         @(negedge clk);
      end
      chk(cyc == v.s + exp_a + v.h + 4, $sformatf("R4 vec%0d busy length", idx), cyc, v.s + exp_a + v.h + 4);
      chk(first == v.s + 1, $sformatf("R4 vec%0d setup length", idx), first, v.s + 1);
      chk(n_str == exp_a + 1, $sformatf("R4/R5 vec%0d active strobe cycles", idx), n_str, exp_a + 1);
      chk(n_nvh == v.h + 1, $sformatf("R4 vec%0d hold cycles", idx), n_nvh, v.h + 1);
      chk(n_other == 0 && n_badq == 0, $sformatf("R8 vec%0d wrong strobe", idx), n_other + n_badq, 0);
      chk(n_badaddr == 0, $sformatf("R7 vec%0d flash address", idx), n_badaddr, 0);
      rd(A_STAT, st);
      chk(st == 32'd0, $sformatf("R3 vec%0d status idle", idx), st, 0);
   endtask

   initial begin : main
      logic [31:0] d;
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(A_CTRL, d); chk(d == 0, "R1 control", d, 0);
      rd(A_TIMA, d); chk(d == 0, "R1 timing-A", d, 0);
      rd(A_TIMB, d); chk(d == 0, "R1 timing-B", d, 0);
      rd(A_TIMC, d); chk(d == 0, "R1 timing-C", d, 0);
      rd(A_ADDR, d); chk(d == 0, "R1 address", d, 0);
      rd(A_STAT, d); chk(d == 0, "R1 status", d, 0);
      chk({busy, mac_erase, mac_erase_all, mac_erase_ref, mac_prog, mac_recall, mac_nvh} == 0 && mac_addr == 0,
          "R1 outputs", {busy, mac_nvh}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 field masks
      wr(A_TIMA, 32'hFFFF_FFFF); wr(A_TIMB, 32'hFFFF_FFFF);
      wr(A_TIMC, 32'hFFFF_FFFF); wr(A_ADDR, 32'hFFFF_FFFF);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_TIMA, d); chk(d == 32'hFFFF_003F, "R2 timing-A mask", d, 32'hFFFF_003F);
      rd(A_TIMB, d); chk(d == 32'h00FF_FFFF, "R2 timing-B mask", d, 32'h00FF_FFFF);
      rd(A_TIMC, d); chk(d == 32'h0FFF_FFFF, "R2 timing-C mask", d, 32'h0FFF_FFFF);
      rd(A_ADDR, d); chk(d == 32'h0000_FFFF, "R2 address mask", d, 32'h0000_FFFF);
      rd(A_STAT, d); chk(d == 32'h0, "R2 status ignores write", d, 0);

      // R9 flags only, no operation bit
      wr(A_CTRL, 32'h0000_0107);
      chk(busy == 1'b0, "R9 no busy", busy, 0);
      rd(A_CTRL, d); chk(d == 32'h103, "R9 flag readback", d, 32'h103);
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R9 still idle", busy, 0);

      // table of operations: R3 R4 R5 R7 R8
      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

      // R6 control write while busy
      wr(A_TIMA, 32'h0002_0000); wr(A_TIMB, 32'd40); wr(A_TIMC, 32'h0100_0000);
      wr(A_CTRL, 32'h0000_0008);
      wr(A_CTRL, 32'h0000_0183);
      rd(A_CTRL, d); chk(d == 32'h008, "R6 ignored while busy", d, 32'h008);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      rd(A_CTRL, d); chk(d == 32'h000, "R6 flags unchanged", d, 32'h000);
      n = 0;
      repeat (4) begin @(negedge clk); n += int'(busy); end
      chk(n == 0, "R6 no deferred start", n, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule